// File: doc/BRIEF.md
# Quadword DMA Command Splitter

This block accepts one byte-granular copy request at a time, made of a source address, a destination address and a byte count. It turns that request into a stream of commands that a quadword-organised DMA engine can run directly. The engine accepts two kinds of command. A bulk command moves a whole number of 16-byte quadwords between two 16-byte aligned addresses. A small command moves 1, 2, 4 or 8 bytes between two addresses that are multiples of that size.

The splitter first walks up to the next quadword boundary with small pieces. It then issues the largest bulk commands allowed and finishes any remainder with small pieces. Each piece is the largest size that both the current alignment and the remaining byte count permit. A request whose source and destination differ in their low four address bits cannot be served by direct commands, because it would need a staging buffer. The block reports such a request as an error and emits nothing. Completion and error are each signalled by a one-cycle pulse.

Top module: `dma_cmd_splitter`

## Requirements
- R1: During and right after reset, req_ready is 1 and cmd_valid, done and err are all 0.
- R2: A bulk command (cmd_kind = 0) carries a cmd_bytes value that is a nonzero multiple of 16 and at most MAX_QW*16 (16384 by default).
- R3: A bulk command is issued only when cmd_src and cmd_dst both have their low four bits equal to zero, and whenever that holds with at least 16 bytes left.
- R4: A small command (cmd_kind = 1) carries a cmd_bytes value of 1, 2, 4 or 8. Its address is a multiple of its size, and the size is the largest such value that does not exceed the bytes left.
- R5: A 7-byte request at a quadword-aligned address is emitted as small commands of 4, then 2, then 1 bytes.
- R6: A request at an aligned address longer than MAX_QW*16 bytes is emitted as successive maximal bulk commands, then one bulk command for the remaining whole quadwords, then small commands for the tail.
- R7: A nonzero-length request whose source and destination low four address bits differ gives a one-cycle err pulse in the cycle after acceptance. It gives no done and no command.
- R8: A zero-length request gives a one-cycle done pulse in the cycle after acceptance and no command, whatever its alignment.
- R9: While cmd_valid is 1 and cmd_ready is 0, cmd_kind, cmd_src, cmd_dst, cmd_bytes and cmd_last stay unchanged and cmd_valid stays 1.
- R10: Commands are contiguous. The first starts at the request addresses, each later one starts where the previous ended, and their byte counts sum to the request length. cmd_last is 1 only on the final command, and done pulses in the cycle after the final command is taken.
- R11: req_ready is 0 from the cycle after a command-producing request is accepted until the cycle after its final command is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_src | input | ADDR_W | Source byte address |
| req_dst | input | ADDR_W | Destination byte address |
| req_len | input | LEN_W | Byte count |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Command taken by the engine |
| cmd_kind | output | 1 | 0 bulk quadword command, 1 small command |
| cmd_src | output | ADDR_W | Command source address |
| cmd_dst | output | ADDR_W | Command destination address |
| cmd_bytes | output | LEN_W | Bytes moved by this command |
| cmd_last | output | 1 | Final command of the request |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle offset-mismatch pulse |

## Verification
The assertions check on every cycle the legality of each offered command: bulk alignment and cap, small size and natural alignment. They also check that commands hold still under backpressure and that the err and done pulses follow a mismatched or empty request, or the final handshake, by exactly one cycle. Only the bench's scenarios can show that a request is cut into the right pieces in the right order: largest fitting piece first, contiguous addresses, a total equal to the length, and the 4-2-1 and over-cap splits.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

  typedef enum logic {
    KIND_BULK  = 1'b0,
    KIND_SMALL = 1'b1
  } cmd_kind_e;

  localparam int QW_LG2   = 4;
  localparam int QW_BYTES = 1 << QW_LG2;

  // Largest of 8/4/2/1 that divides the offset and fits in room (room >= 1)
  function automatic logic [3:0] pick_small(input logic [3:0] off, input logic [3:0] room);
    if (off[2:0] == 3'd0 && room >= 4'd8) return 4'd8;
    if (off[1:0] == 2'd0 && room >= 4'd4) return 4'd4;
    if (!off[0] && room >= 4'd2)          return 4'd2;
    return 4'd1;
  endfunction

endpackage

// File: rtl/dcs_req_check.sv
module dcs_req_check #(
  parameter int LEN_W = 20
) (
  input  logic [3:0]       src_off,
  input  logic [3:0]       dst_off,
  input  logic [LEN_W-1:0] len,
  output logic             is_zero,
  output logic             is_skew
);
  assign is_zero = (len == '0);
  assign is_skew = (src_off != dst_off);
endmodule

// File: rtl/dcs_piece_sel.sv
module dcs_piece_sel
  import dcs_pkg::*;
#(
  parameter int LEN_W  = 20,
  parameter int MAX_QW = 1024
) (
  input  logic [3:0]       off,
  input  logic [LEN_W-1:0] rem,
  output cmd_kind_e        kind,
  output logic [LEN_W-1:0] bytes
);
  localparam logic [LEN_W-1:0] CAP_QW    = LEN_W'(MAX_QW);
  localparam logic [LEN_W-1:0] CAP_BYTES = LEN_W'(MAX_QW * QW_BYTES);
  localparam logic [LEN_W-1:0] QW_MASK   = ~LEN_W'(QW_BYTES - 1);

  logic [LEN_W-1:0] qw_avail;
  logic             bulk_ok;
  logic [LEN_W-1:0] bulk_bytes;
  logic [3:0]       room;
  logic [3:0]       small_bytes;

  assign qw_avail    = rem >> QW_LG2;
  assign bulk_ok     = (off == 4'd0) && (qw_avail != '0);
  assign bulk_bytes  = (qw_avail > CAP_QW) ? CAP_BYTES : (rem & QW_MASK);
  assign room        = (rem > LEN_W'(15)) ? 4'hF : rem[3:0];
  assign small_bytes = pick_small(off, room);

  always_comb begin
    if (bulk_ok) begin
      kind  = KIND_BULK;
      bytes = bulk_bytes;
    end else begin
      kind  = KIND_SMALL;
      bytes = LEN_W'(small_bytes);
    end
  end
endmodule

// File: rtl/dcs_walker.sv
module dcs_walker #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              is_zero,
  input  logic              is_skew,
  input  logic [ADDR_W-1:0] req_src,
  input  logic [ADDR_W-1:0] req_dst,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              fire,
  input  logic [LEN_W-1:0]  step_bytes,
  output logic              busy,
  output logic [ADDR_W-1:0] cur_src,
  output logic [ADDR_W-1:0] cur_dst,
  output logic [LEN_W-1:0]  rem,
  output logic              step_last,
  output logic              done_q,
  output logic              err_q
);
  assign step_last = (rem == step_bytes);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cur_src <= '0;
      cur_dst <= '0;
      rem     <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (accept) begin
        if (is_zero) begin
          done_q <= 1'b1;
        end else if (is_skew) begin
          err_q <= 1'b1;
        end else begin
          busy    <= 1'b1;
          cur_src <= req_src;
          cur_dst <= req_dst;
          rem     <= req_len;
        end
      end else if (fire) begin
        cur_src <= cur_src + ADDR_W'(step_bytes);
        cur_dst <= cur_dst + ADDR_W'(step_bytes);
        rem     <= rem - step_bytes;
        if (step_last) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dma_cmd_splitter.sv
module dma_cmd_splitter
  import dcs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 20,
  parameter int MAX_QW = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_src,
  input  logic [ADDR_W-1:0] req_dst,
  input  logic [LEN_W-1:0]  req_len,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_kind,
  output logic [ADDR_W-1:0] cmd_src,
  output logic [ADDR_W-1:0] cmd_dst,
  output logic [LEN_W-1:0]  cmd_bytes,
  output logic              cmd_last,
  output logic              done,
  output logic              err
);
  logic              accept;
  logic              fire;
  logic              is_zero;
  logic              is_skew;
  logic              busy;
  logic [ADDR_W-1:0] cur_src;
  logic [ADDR_W-1:0] cur_dst;
  logic [LEN_W-1:0]  rem;
  logic              step_last;
  logic [LEN_W-1:0]  step_bytes;
  cmd_kind_e         step_kind;
  logic              done_q;
  logic              err_q;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign cmd_valid = busy;
  assign fire      = cmd_valid && cmd_ready;

  dcs_req_check #(.LEN_W(LEN_W)) u_chk_req (
    .src_off (req_src[3:0]),
    .dst_off (req_dst[3:0]),
    .len     (req_len),
    .is_zero (is_zero),
    .is_skew (is_skew)
  );

  dcs_piece_sel #(.LEN_W(LEN_W), .MAX_QW(MAX_QW)) u_sel (
    .off   (cur_src[3:0]),
    .rem   (rem),
    .kind  (step_kind),
    .bytes (step_bytes)
  );

  dcs_walker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_walk (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .is_zero    (is_zero),
    .is_skew    (is_skew),
    .req_src    (req_src),
    .req_dst    (req_dst),
    .req_len    (req_len),
    .fire       (fire),
    .step_bytes (step_bytes),
    .busy       (busy),
    .cur_src    (cur_src),
    .cur_dst    (cur_dst),
    .rem        (rem),
    .step_last  (step_last),
    .done_q     (done_q),
    .err_q      (err_q)
  );

  assign cmd_kind  = step_kind;
  assign cmd_src   = cur_src;
  assign cmd_dst   = cur_dst;
  assign cmd_bytes = step_bytes;
  assign cmd_last  = busy && step_last;
  assign done      = done_q;
  assign err       = err_q;
endmodule

// File: rtl/dcs_checks.sv
module dcs_checks #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 20,
  parameter int MAX_QW = 1024
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_src,
  input logic [ADDR_W-1:0] req_dst,
  input logic [LEN_W-1:0]  req_len,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cmd_kind,
  input logic [ADDR_W-1:0] cmd_src,
  input logic [ADDR_W-1:0] cmd_dst,
  input logic [LEN_W-1:0]  cmd_bytes,
  input logic              cmd_last,
  input logic              done,
  input logic              err,
  input logic              fire
);
  localparam logic [LEN_W-1:0] CAP = LEN_W'(MAX_QW * 16);

  p_bulk_size_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_kind |-> (cmd_bytes != '0) && (cmd_bytes[3:0] == 4'd0) && (cmd_bytes <= CAP));

  p_bulk_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_kind |-> (cmd_src[3:0] == 4'd0) && (cmd_dst[3:0] == 4'd0));

  p_small_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_kind |-> $onehot(cmd_bytes) && (cmd_bytes <= LEN_W'(8))
      && ((cmd_src[3:0] & (cmd_bytes[3:0] - 4'd1)) == 4'd0)
      && ((cmd_dst[3:0] & (cmd_bytes[3:0] - 4'd1)) == 4'd0));

  p_skew_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (req_len != '0) && (req_src[3:0] != req_dst[3:0])
      |=> err && !done && !cmd_valid);

  p_empty_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (req_len == '0) |=> done && !err && !cmd_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_kind) && $stable(cmd_src)
      && $stable(cmd_dst) && $stable(cmd_bytes) && $stable(cmd_last));

  p_last_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fire && cmd_last |=> done && !cmd_valid);

  p_step_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !cmd_last |=> cmd_valid && !done && (cmd_src == $past(cmd_src) + ADDR_W'($past(cmd_bytes))));

  p_busy_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !cmd_last |=> !req_ready);

  p_pulse_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
endmodule

bind dma_cmd_splitter dcs_checks #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_QW(MAX_QW)) u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_src   (req_src),
  .req_dst   (req_dst),
  .req_len   (req_len),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_kind  (cmd_kind),
  .cmd_src   (cmd_src),
  .cmd_dst   (cmd_dst),
  .cmd_bytes (cmd_bytes),
  .cmd_last  (cmd_last),
  .done      (done),
  .err       (err),
  .fire      (fire)
);

// File: tb/sim_dma_cmd_splitter.sv
module sim_dma_cmd_splitter;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 20;
  localparam int NVEC   = 9;

  // {src, dst, len}
  localparam logic [95:0] VEC [NVEC] = '{
    {32'h0000_1000, 32'h0000_2000, 32'd64},
    {32'h0000_1003, 32'h0000_5003, 32'd29},
    {32'h0000_0100, 32'h0000_0200, 32'd7},
    {32'h0000_0010, 32'h0000_0030, 32'd40005},
    {32'h0000_0007, 32'h0000_0017, 32'd1},
    {32'h0000_0002, 32'h0000_0042, 32'd100},
    {32'h0000_000A, 32'h0000_000B, 32'd5},
    {32'h0000_0004, 32'h0000_0008, 32'd0},
    {32'h0000_0000, 32'h0000_4000, 32'd16384}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_src = '0;
  logic [ADDR_W-1:0] req_dst = '0;
  logic [LEN_W-1:0]  req_len = '0;
  logic              cmd_valid;
  logic              cmd_ready = 1'b0;
  logic              cmd_kind;
  logic [ADDR_W-1:0] cmd_src;
  logic [ADDR_W-1:0] cmd_dst;
  logic [LEN_W-1:0]  cmd_bytes;
  logic              cmd_last;
  logic              done;
  logic              err;

  int n_run = 0;
  int n_fail = 0;
  int got_kinds [$];
  int got_sizes [$];

  always #4 clk = ~clk;

  dma_cmd_splitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_QW(1024)) u0 (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected next piece, restated from R3/R4/R2: kind 0 bulk, 1 small
  task automatic model(input longint a, input longint left, output int kind, output longint nb);
    if (a % 16 == 0 && left >= 16) begin
      longint q = left / 16;
      if (q > 1024) q = 1024;
      kind = 0;
      nb = q * 16;
    end else begin
      longint s = 8;
      while (s > 1 && ((a % s) != 0 || s > left)) s = s / 2;
      kind = 1;
      nb = s;
    end
  endtask

  task automatic run_req(input longint s, input longint d, input longint len, input bit stall);
    longint es = s, ed = d, left = len;
    int step = 0;
    got_kinds.delete();
    got_sizes.delete();
    @(negedge clk);
    req_valid = 1'b1; req_src = ADDR_W'(s); req_dst = ADDR_W'(d); req_len = LEN_W'(len);
    @(negedge clk);
    req_valid = 1'b0;
    if (len == 0) begin
      chk(done && !cmd_valid && !err, "R8 empty request done", {done, cmd_valid}, 2);
      @(negedge clk);
      chk(!done && !cmd_valid, "R8 single pulse", {done, cmd_valid}, 0);
      return;
    end
    if ((s % 16) != (d % 16)) begin
      chk(err && !cmd_valid && !done, "R7 mismatch err", {err, cmd_valid, done}, 4);
      @(negedge clk);
      chk(!err && !cmd_valid && req_ready, "R7 nothing emitted", {err, cmd_valid, req_ready}, 1);
      return;
    end
    while (left > 0 && step < 64) begin
      int k; longint nb;
      model(es, left, k, nb);
      chk(cmd_valid && !req_ready, "R11 busy blocks requests", {cmd_valid, req_ready}, 2);
      chk(cmd_kind == k[0] && cmd_bytes == LEN_W'(nb),
          (k == 0) ? "R3 bulk piece" : "R4 small piece", {cmd_kind, cmd_bytes}, (longint'(k) << LEN_W) | nb);
      chk(cmd_src == ADDR_W'(es) && cmd_dst == ADDR_W'(ed), "R10 contiguous address", cmd_src, es);
      chk(cmd_last == (nb == left), "R10 last flag", cmd_last, longint'(nb == left));
      got_kinds.push_back(int'(cmd_kind));
      got_sizes.push_back(int'(cmd_bytes));
      if (stall && step % 2 == 0) begin
        logic [ADDR_W-1:0] hs = cmd_src;
        logic [LEN_W-1:0]  hb = cmd_bytes;
        logic              hk = cmd_kind;
        cmd_ready = 1'b0;
        @(negedge clk);
        chk(cmd_valid && cmd_src == hs && cmd_bytes == hb && cmd_kind == hk,
            "R9 hold under stall", cmd_bytes, hb);
      end
      cmd_ready = 1'b1;
      @(negedge clk);
      cmd_ready = 1'b0;
      es += nb; ed += nb; left -= nb; step++;
    end
    chk(done && !cmd_valid && req_ready, "R10 done after final", {done, cmd_valid, req_ready}, 5);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R10 actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && !cmd_valid && !done && !err, "R1 reset state",
        {req_ready, cmd_valid, done, err}, 8);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !cmd_valid && !done && !err, "R1 after reset",
        {req_ready, cmd_valid, done, err}, 8);

    for (int i = 0; i < NVEC; i++) begin
      run_req(longint'(VEC[i][95:64]), longint'(VEC[i][63:32]), longint'(VEC[i][31:0]), i[0]);
    end

    // R5: 7 bytes at an aligned address -> 4, 2, 1
    run_req(64'h300, 64'h900, 7, 1'b0);
    chk(got_sizes.size() == 3 && got_sizes[0] == 4 && got_sizes[1] == 2 && got_sizes[2] == 1
        && got_kinds[0] == 1 && got_kinds[2] == 1, "R5 seven byte split",
        got_sizes.size(), 3);

    // R6: 40005 bytes aligned -> 16384, 16384, 7232 bulk, then 4 and 1
    run_req(64'h10000, 64'h20000, 40005, 1'b1);
    chk(got_sizes.size() == 5 && got_sizes[0] == 16384 && got_sizes[1] == 16384
        && got_sizes[2] == 7232 && got_kinds[2] == 0 && got_sizes[3] == 4 && got_sizes[4] == 1,
        "R6 over-cap split", got_sizes.size(), 5);

    // R2: exactly the cap is one bulk command
    run_req(64'h0, 64'h8000, 16384, 1'b0);
    chk(got_sizes.size() == 1 && got_sizes[0] == 16384 && got_kinds[0] == 0,
        "R2 single max bulk", got_sizes.size(), 1);

    // R8: zero length with mismatched offsets still completes
    run_req(64'h3, 64'h5, 0, 1'b0);

    // R3: unaligned start walks up by small pieces before bulk
    run_req(64'h1001, 64'h3001, 48, 1'b1);
    chk(got_sizes.size() >= 4 && got_kinds[0] == 1 && got_kinds[4] == 0,
        "R3 head then bulk", got_sizes.size(), 6);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule